// File: doc/BRIEF.md
# Electroluminescent Panel Drive Sequencer

This block produces the two switching clocks that an external transistor stage needs to pump an electroluminescent panel up to a high AC voltage. The first clock, `elc`, charges the panel. The second, `elp`, drives the boost inductor. Each output has its own selectable source, rate and duty. Both outputs come from level prescaler taps that are supplied from outside. The block finds their rising edges with edge detectors clocked by the system clock.

A light-on pulse and a light-off pulse make the block start and stop the outputs in a safe order. On start, `elc` begins first. `elp` is released only after `elc` has finished its first high phase. On stop, both outputs keep running until the current or next `elc` high phase ends, and then both go low together, so no charge is left on the panel. While a sequence is in progress, `busy` is high and the configuration register is frozen.

Top module: `el_seq`

## Requirements
- R1: Synchronous active-high reset puts the block idle. While idle, `elc`, `elp` and `busy` are all low.
- R2: The configuration word is `{elp_sys[8], elp_div[7:6], elp_duty[5:4], elc_tap[3:2], elc_duty[1:0]}`. With `elp_sys`=1 the pump source ticks every clock. With `elp_sys`=0 it ticks on each rising edge of `ph0_tap`. `elp_div` divides the source ticks: 00=/1, 01=/2, 10=/4, 11=/8.
- R3: The duty codes for both outputs are 00=1/4, 01=1/3, 10=1/2, 11=1/1. A code gives a period of 4, 3, 2 or 1 rate ticks, and the output is high for the first tick interval of each period. With 1/1 the output stays high while it is enabled.
- R4: The charge clock rate tick is a rising edge of `elc_taps[elc_tap]`, with tap index 3 the fastest tap and index 0 the slowest.
- R5: After light-on, `elc` rises at the first selected-tap rising edge. `elp` stays low until the clock edge that ends that first `elc` high phase, and rises exactly then. Until that edge, `elc` is high with `elp` low for exactly one `elc` tick interval.
- R6: After light-off, both outputs keep running until an `elc` high phase ends, then both go low in the same cycle. With `elc` duty 1/1, the next selected-tap rising edge counts as that end.
- R7: `busy` rises in the cycle after an accepted light-on and falls in the same cycle that the outputs stop.
- R8: A configuration write while `busy` is high has no effect. The running sequence and any later sequence keep the earlier configuration.
- R9: A light-off that arrives before `elc` has first risen returns the block to idle at once. `elc` never pulses.
- R10: Light-off while idle and light-on while busy are ignored. A light-on during shutdown does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph0_tap | input | 1 | Fastest prescaler tap, optional pump clock source |
| elc_taps | input | 4 | Prescaler taps for the charge clock (index 3 fastest) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 9 | Configuration word (layout in R2) |
| light_on | input | 1 | Start command pulse |
| light_off | input | 1 | Stop command pulse |
| elc | output | 1 | Charge clock output |
| elp | output | 1 | Pump clock output |
| busy | output | 1 | High from start until shutdown completes |

## Verification
The hardest state to reach from the ports is the short arming window. This is the time between light-on and the first rising edge of the selected tap, and a light-off must land inside it. The stimulus picks the slowest tap and tracks the free-running tap counter that it drives. It issues light-on just as that tap has risen and light-off one cycle later, so the abort lands about thirty cycles before any charge pulse could start. A light-on issued during shutdown is the second hard case. It is placed one cycle after light-off while the slow charge clock sits in its long low phase, so the block is surely still draining.

// File: rtl/el_drv_pkg.sv
package el_drv_pkg;

    localparam int NUM_ELC_TAPS = 4;
    localparam int TAP_SEL_W    = $clog2(NUM_ELC_TAPS);
    localparam int CODE_W       = 2;
    localparam int PHASE_W      = 2;
    localparam int PRE_W        = 3;

    typedef struct packed {
        logic                 elp_sys;
        logic [CODE_W-1:0]    elp_div;
        logic [CODE_W-1:0]    elp_duty;
        logic [TAP_SEL_W-1:0] elc_tap;
        logic [CODE_W-1:0]    elc_duty;
    } el_cfg_t;

    localparam int CFG_W = $bits(el_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LEAD,
        ST_RUN,
        ST_DRAIN
    } el_state_t;

    // last phase index of a period: code 11 -> 0 (1 tick), 00 -> 3 (4 ticks)
    function automatic logic [PHASE_W-1:0] duty_last(input logic [CODE_W-1:0] code);
        return PHASE_W'(2'd3 - code);
    endfunction

    // last prescale count: /1, /2, /4, /8
    function automatic logic [PRE_W-1:0] div_last(input logic [CODE_W-1:0] code);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(1) << code;
        return PRE_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/el_edge_tick.sv
module el_edge_tick #(
    parameter int N_TAPS = 4,
    parameter int SEL_W  = 2,
    parameter bit BYPASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]  sel,
    input  logic              every_clk,
    output logic              tick
);
    logic [N_TAPS-1:0] taps_q;
    logic [N_TAPS-1:0] rises;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) taps_q[g] <= 1'b0;
            else     taps_q[g] <= taps[g];
        end
        assign rises[g] = taps[g] & ~taps_q[g];
    end

    if (BYPASS) begin : g_bypass
        assign tick = every_clk | rises[sel];
    end else begin : g_plain
        logic unused_every;
        assign unused_every = every_clk;
        assign tick = rises[sel];
    end
endmodule

// File: rtl/el_rate_div.sv
module el_rate_div #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] last,
    output logic             tick_out
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_out = en && tick_in && (cnt_q == last);
endmodule

// File: rtl/el_duty_gen.sv
module el_duty_gen #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [PH_W-1:0] last,
    output logic            pulse
);
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
        end
    end

    assign pulse = en && (phase_q == '0);
endmodule

// File: rtl/el_seq.sv
module el_seq
    import el_drv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ph0_tap,
    input  logic [NUM_ELC_TAPS-1:0] elc_taps,
    input  logic                    cfg_wr,
    input  logic [CFG_W-1:0]        cfg_word,
    input  logic                    light_on,
    input  logic                    light_off,
    output logic                    elc,
    output logic                    elp,
    output logic                    busy
);
    el_cfg_t   cfg_q;
    el_state_t state_q;
    logic      elc_en_q;
    logic      elp_en_q;

    logic      elc_tick;
    logic      elc_hi_end;
    logic      elp_src_tick;
    logic      elp_rate_tick;

    // configuration is frozen while a sequence is in progress
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr && state_q == ST_IDLE) begin
            cfg_q <= el_cfg_t'(cfg_word);
        end
    end

    // charge clock path
    el_edge_tick #(
        .N_TAPS (NUM_ELC_TAPS),
        .SEL_W  (TAP_SEL_W),
        .BYPASS (1'b0)
    ) u_elc_tick (
        .clk       (clk),
        .rst       (rst),
        .taps      (elc_taps),
        .sel       (cfg_q.elc_tap),
        .every_clk (1'b0),
        .tick      (elc_tick)
    );

    el_duty_gen #(.PH_W(PHASE_W)) u_elc_duty (
        .clk   (clk),
        .rst   (rst),
        .en    (elc_en_q),
        .tick  (elc_tick),
        .last  (duty_last(cfg_q.elc_duty)),
        .pulse (elc)
    );

    // a high phase ends at the rate tick seen while the output is high
    assign elc_hi_end = elc && elc_tick;

    // pump clock path
    el_edge_tick #(
        .N_TAPS (1),
        .SEL_W  (1),
        .BYPASS (1'b1)
    ) u_elp_tick (
        .clk       (clk),
        .rst       (rst),
        .taps      (ph0_tap),
        .sel       (1'b0),
        .every_clk (cfg_q.elp_sys),
        .tick      (elp_src_tick)
    );

    el_rate_div #(.CNT_W(PRE_W)) u_elp_div (
        .clk      (clk),
        .rst      (rst),
        .en       (elp_en_q),
        .tick_in  (elp_src_tick),
        .last     (div_last(cfg_q.elp_div)),
        .tick_out (elp_rate_tick)
    );

    el_duty_gen #(.PH_W(PHASE_W)) u_elp_duty (
        .clk   (clk),
        .rst   (rst),
        .en    (elp_en_q),
        .tick  (elp_rate_tick),
        .last  (duty_last(cfg_q.elp_duty)),
        .pulse (elp)
    );

    // start / stop sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            elc_en_q <= 1'b0;
            elp_en_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (light_on) state_q <= ST_ARM;
                end
                ST_ARM: begin
                    if (light_off) begin
                        state_q <= ST_IDLE;
                    end else if (elc_tick) begin
                        state_q  <= ST_LEAD;
                        elc_en_q <= 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (elc_hi_end && light_off) begin
                        state_q  <= ST_IDLE;
                        elc_en_q <= 1'b0;
                    end else if (elc_hi_end) begin
                        state_q  <= ST_RUN;
                        elp_en_q <= 1'b1;
                    end else if (light_off) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_RUN: begin
                    if (light_off && elc_hi_end) begin
                        state_q  <= ST_IDLE;
                        elc_en_q <= 1'b0;
                        elp_en_q <= 1'b0;
                    end else if (light_off) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (elc_hi_end) begin
                        state_q  <= ST_IDLE;
                        elc_en_q <= 1'b0;
                        elp_en_q <= 1'b0;
                    end
                end
                default: begin
                    state_q  <= ST_IDLE;
                    elc_en_q <= 1'b0;
                    elp_en_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/el_seq_chk.sv
module el_seq_chk
    import el_drv_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      light_on,
    input logic      light_off,
    input logic      elc,
    input logic      elp,
    input logic      busy,
    input el_state_t state,
    input el_cfg_t   cfg_q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!elc && !elp));

    p_arm_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM) |-> (!elc && !elp));

    p_lead_no_pump_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEAD) |-> !elp);

    p_stop_together_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(state) != ST_ARM) |-> (!elc && !elp && $past(elc)));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (light_on && !busy) |=> busy);

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM && light_off) |=> !busy);

    p_off_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !light_on) |=> !busy);
endmodule

bind el_seq el_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .light_on  (light_on),
    .light_off (light_off),
    .elc       (elc),
    .elp       (elp),
    .busy      (busy),
    .state     (state_q),
    .cfg_q     (cfg_q)
);

// File: tb/el_seq_test.sv
module el_seq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       ph0_tap;
    logic [3:0] elc_taps;
    logic       cfg_wr;
    logic [8:0] cfg_word;
    logic       light_on;
    logic       light_off;
    logic       elc;
    logic       elp;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    logic [7:0] div_cnt = 8'd0;

    always #2 clk = ~clk;

    // free prescaler model: ph0 ticks every 2 cycles; tap3..tap0 every 4,8,16,32
    always @(negedge clk) div_cnt <= div_cnt + 8'd1;
    assign ph0_tap  = div_cnt[0];
    assign elc_taps = {div_cnt[1], div_cnt[2], div_cnt[3], div_cnt[4]};

    el_seq uut (
        .clk       (clk),
        .rst       (rst),
        .ph0_tap   (ph0_tap),
        .elc_taps  (elc_taps),
        .cfg_wr    (cfg_wr),
        .cfg_word  (cfg_word),
        .light_on  (light_on),
        .light_off (light_off),
        .elc       (elc),
        .elp       (elp),
        .busy      (busy)
    );

    // {cfg[40:32], elc_hi[31:24], elc_per[23:16], elp_hi[15:8], elp_per[7:0]}; per 0 = constant high
    localparam logic [40:0] VEC [6] = '{
        {9'b1_00_00_11_10, 8'd4,  8'd8,   8'd1, 8'd4},
        {9'b0_01_01_10_01, 8'd8,  8'd24,  8'd4, 8'd12},
        {9'b1_11_10_01_00, 8'd16, 8'd64,  8'd8, 8'd16},
        {9'b0_10_11_00_10, 8'd32, 8'd64,  8'd8, 8'd0},
        {9'b1_10_00_11_11, 8'd4,  8'd0,   8'd4, 8'd16},
        {9'b0_00_10_00_00, 8'd32, 8'd128, 8'd2, 8'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic smp();
        @(posedge clk);
        #1;
    endtask

    function automatic logic rd(input int which);
        return (which == 0) ? elc : elp;
    endfunction

    task automatic write_cfg(input logic [8:0] w);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic pulse_on();
        @(negedge clk);
        light_on = 1'b1;
        @(negedge clk);
        light_on = 1'b0;
    endtask

    // samples with elc high and elp low until elp first rises
    task automatic lead_count(output int n);
        n = 0;
        for (int t = 0; t < 2000; t++) begin
            smp();
            if (elp) break;
            if (elc) n++;
        end
    endtask

    task automatic measure(input int which, output int hi, output int per);
        logic prev;
        hi = 0;
        per = 0;
        prev = rd(which);
        for (int t = 0; t < 2000; t++) begin
            smp();
            if (!prev && rd(which)) break;
            prev = rd(which);
        end
        hi = 1;
        for (int t = 0; t < 2000; t++) begin
            smp();
            if (!rd(which)) break;
            hi++;
        end
        per = hi;
        for (int t = 0; t < 2000; t++) begin
            per++;
            smp();
            if (rd(which)) break;
        end
    endtask

    task automatic check_wave(input int which, input int exp_hi, input int exp_per, input string req);
        int hi;
        int per;
        if (exp_per == 0) begin
            hi = 0;
            for (int t = 0; t < 150; t++) begin
                smp();
                if (rd(which)) hi++;
            end
            check({req, " constant high"}, hi, 150);
        end else begin
            measure(which, hi, per);
            check({req, " high length"}, hi, exp_hi);
            check({req, " period"}, per, exp_per);
        end
    endtask

    // R6 / R7: shutdown aligned to an elc high-phase end, both low together
    task automatic shut_down();
        logic pe;
        int   low_n;
        @(negedge clk);
        pe = elc;
        light_off = 1'b1;
        @(negedge clk);
        light_off = 1'b0;
        for (int t = 0; t < 2000 && busy; t++) begin
            pe = elc;
            smp();
        end
        check("R7 busy dropped", busy, 0);
        check("R6 elc high before stop", pe, 1);
        check("R6 both low at stop", {elc, elp}, 0);
        low_n = 0;
        for (int t = 0; t < 40; t++) begin
            smp();
            if (!elc && !elp && !busy) low_n++;
        end
        check("R6 stays stopped", low_n, 40);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int hi;
        int per;
        logic [40:0] v;
        rst       = 1'b1;
        cfg_wr    = 1'b0;
        cfg_word  = '0;
        light_on  = 1'b0;
        light_off = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        smp();
        check("R1 reset outputs", {elc, elp, busy}, 0);

        // table of configurations: R2, R3, R4, R5, R6, R7
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            write_cfg(v[40:32]);
            pulse_on();
            check("R7 busy after on", busy, 1);
            lead_count(n);
            check("R5 elc leads elp by one elc tick", n, int'(v[31:24]));
            check_wave(0, int'(v[31:24]), int'(v[23:16]), "R4 R3 elc");
            check_wave(1, int'(v[15:8]), int'(v[7:0]), "R2 R3 elp");
            shut_down();
        end

        // R8: writes while busy are ignored, now and for the next run
        write_cfg(VEC[0][40:32]);
        pulse_on();
        lead_count(n);
        write_cfg(VEC[2][40:32]);
        measure(0, hi, per);
        check("R8 elc period after busy write", per, 8);
        shut_down();
        pulse_on();
        lead_count(n);
        check("R8 restart lead", n, 4);
        measure(0, hi, per);
        check("R8 restart elc period", per, 8);
        measure(1, hi, per);
        check("R8 restart elp period", per, 4);
        shut_down();

        // R10: light-off while idle is ignored
        @(negedge clk);
        light_off = 1'b1;
        @(negedge clk);
        light_off = 1'b0;
        smp();
        check("R10 off in idle", {elc, elp, busy}, 0);

        // R10: light-on during shutdown does not restart
        write_cfg(VEC[5][40:32]);
        pulse_on();
        lead_count(n);
        @(negedge clk);
        light_off = 1'b1;
        @(negedge clk);
        light_off = 1'b0;
        light_on  = 1'b1;
        @(negedge clk);
        light_on  = 1'b0;
        for (int t = 0; t < 400 && busy; t++) smp();
        n = 0;
        for (int t = 0; t < 200; t++) begin
            smp();
            if (busy || elc || elp) n++;
        end
        check("R10 on during drain ignored", n, 0);

        // R9: abort before the first elc edge (slowest tap, just after it rose)
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (div_cnt[4:0] == 5'd15) break;
        end
        light_on = 1'b1;
        @(negedge clk);
        light_on  = 1'b0;
        light_off = 1'b1;
        @(negedge clk);
        light_off = 1'b0;
        check("R9 busy cleared by early off", busy, 0);
        n = 0;
        for (int t = 0; t < 80; t++) begin
            smp();
            if (elc || elp || busy) n++;
        end
        check("R9 no elc pulse after abort", n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule